// File: doc/BRIEF.md
# Over-Current Fault Latch Controller

This block is the shared protection logic behind a three-phase half-bridge gate driver. It watches the digital over-current comparator result, an enable level, a fault-clear level, a supply undervoltage flag and the three high-side switch commands. Its two outputs go to the rest of the driver. `gate_kill` forces every gate of every phase off. `fault_n` is an active-low fault indication meant to drive an open-drain pin.

All level inputs are first passed through a synchroniser. A blanking timer restarts on each rising edge of any high-side command, and while it runs the comparator is masked. A comparator hit outside that window latches a fault. A supply undervoltage also latches a fault, and so does reset, so the driver comes up latched. The latch has only one way out. Enable must be low, then the clear input must be held high for a minimum time and then dropped. After that the gates stay off until enable has been high for its own minimum time.

The controller is a three-state machine:
- `ST_FAULT`: latched, gates off, `fault_n` low.
- `ST_IDLE`: cleared but disabled, gates off, `fault_n` released.
- `ST_RUN`: gates released.

It has these transitions:
- TRIP: any state to `ST_FAULT`.
- CLEAR: `ST_FAULT` to `ST_IDLE`.
- ARM: `ST_IDLE` to `ST_RUN`.
- DISABLE: `ST_RUN` to `ST_IDLE`.

Top module: `ocf_fault_ctrl`

## Requirements
- R1: After reset, `fault_n` is 0 and `gate_kill` is 1 (fault latched at power-up).
- R2: Each input passes through SYNC_STAGES flip-flops. The state machine acts on the next clock edge, so an input change applied before edge k shows on the outputs after edge k+SYNC_STAGES.
- R3: A synchronised over-current that is high in a cycle with no blanking active latches the fault (TRIP): `fault_n` goes 0 and `gate_kill` goes 1 at the next edge.
- R4: A rising edge on any of the three synchronised high-side commands opens a blanking window. The window covers BLANK_CYCLES cycles, starting with the edge cycle, and the over-current is ignored during it. Each new edge restarts the window. An over-current that is high for exactly the window does not trip, and one that is high one cycle longer does trip.
- R5: A synchronised undervoltage flag latches the fault from any state.
- R6: CLEAR happens when the synchronised clear input falls after at least FRST_MIN consecutive high cycles. Throughout those cycles enable must be low and neither over-current nor undervoltage may be present. On CLEAR, `fault_n` goes 1 and `gate_kill` stays 1.
- R7: A clear pulse shorter than FRST_MIN cycles leaves the fault latched.
- R8: The clear input has no effect while enable is high.
- R9: An over-current during the clear pulse keeps `fault_n` low and restarts the clear-time count.
- R10: ARM happens only after enable has been high for more than EN_MIN consecutive synchronised cycles. A shorter enable pulse leaves `gate_kill` at 1.
- R11: Enable low forces `gate_kill` to 1 at the next edge (DISABLE) and leaves `fault_n` unchanged.
- R12: `gate_kill` is 1 in every cycle in which `fault_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 1 | Over-current comparator result, 1 = over-current |
| en_raw | input | 1 | Enable level, 1 = drive allowed |
| frst_raw | input | 1 | Fault-clear level, active high |
| uv_raw | input | 1 | Supply undervoltage flag, 1 = undervoltage |
| hs_cmd_raw | input | N_PHASE | High-side switch commands, one bit per phase |
| gate_kill | output | 1 | 1 = all gate outputs forced off |
| fault_n | output | 1 | 0 = fault latched (open-drain pull-down) |

## Verification
Two functions can fall in the same cycle. A high-side turn-on can open a blanking window in the very cycle the comparator goes high, and an over-current can arrive while a clear pulse is being timed. The bench raises a high-side command and the over-current in the same cycle, holding the over-current for exactly the window length and then one cycle more. It also lands an over-current pulse in the middle of a long clear pulse. It judges these cases, and a long seeded random run, against a cycle model built from the requirements.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

    typedef enum logic [1:0] {
        ST_FAULT = 2'd0,
        ST_IDLE  = 2'd1,
        ST_RUN   = 2'd2
    } ocf_state_e;

endpackage

// File: rtl/ocf_sync.sv
module ocf_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ocf_blank_timer.sv
module ocf_blank_timer #(
    parameter int N_PHASE      = 3,
    parameter int BLANK_CYCLES = 300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] hs_cmd,
    output logic               hs_rise,
    output logic               blank
);

    localparam int CW = $clog2(BLANK_CYCLES + 1);

    logic [N_PHASE-1:0] hs_prev;
    logic [CW-1:0]      remain;

    assign hs_rise = |(hs_cmd & ~hs_prev);
    assign blank   = hs_rise | (remain != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_prev <= '0;
            remain  <= '0;
        end else begin
            hs_prev <= hs_cmd;
            if (hs_rise)
                remain <= CW'(BLANK_CYCLES - 1);
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/ocf_hold_qual.sv
module ocf_hold_qual #(
    parameter int MIN_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic spoil,
    output logic held,
    output logic released
);

    localparam int CW = $clog2(MIN_CYCLES + 1);

    logic [CW-1:0] count;
    logic          level_prev;
    logic          full;

    assign full     = (count == CW'(MIN_CYCLES));
    assign held     = level & full;
    assign released = level_prev & ~level & full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count      <= '0;
            level_prev <= 1'b0;
        end else begin
            level_prev <= level;
            if (!level || spoil)
                count <= '0;
            else if (!full)
                count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/ocf_fault_ctrl.sv
module ocf_fault_ctrl
    import ocf_pkg::*;
#(
    parameter int N_PHASE      = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 300,
    parameter int FRST_MIN     = 1000,
    parameter int EN_MIN       = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               oc_raw,
    input  logic               en_raw,
    input  logic               frst_raw,
    input  logic               uv_raw,
    input  logic [N_PHASE-1:0] hs_cmd_raw,
    output logic               gate_kill,
    output logic               fault_n
);

    localparam int NLVL = 4;
    localparam int NIN  = NLVL + N_PHASE;

    logic [NIN-1:0]     raw_vec;
    logic [NIN-1:0]     syn_vec;
    logic               oc_s;
    logic               en_s;
    logic               frst_s;
    logic               uv_s;
    logic [N_PHASE-1:0] hs_s;

    logic               hs_rise;
    logic               blank;
    logic               trip;
    logic               frst_held;
    logic               frst_done;
    logic               en_held;
    logic               en_released;
    logic               clr_spoil;

    ocf_state_e         state_q;
    ocf_state_e         state_d;

    assign raw_vec = {hs_cmd_raw, uv_raw, frst_raw, en_raw, oc_raw};

    ocf_sync #(
        .WIDTH (NIN),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_vec),
        .q    (syn_vec)
    );

    assign oc_s   = syn_vec[0];
    assign en_s   = syn_vec[1];
    assign frst_s = syn_vec[2];
    assign uv_s   = syn_vec[3];
    assign hs_s   = syn_vec[NIN-1:NLVL];

    ocf_blank_timer #(
        .N_PHASE     (N_PHASE),
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_cmd (hs_s),
        .hs_rise(hs_rise),
        .blank  (blank)
    );

    assign clr_spoil = en_s | oc_s | uv_s;

    ocf_hold_qual #(
        .MIN_CYCLES(FRST_MIN)
    ) u_frst_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (frst_s),
        .spoil   (clr_spoil),
        .held    (frst_held),
        .released(frst_done)
    );

    ocf_hold_qual #(
        .MIN_CYCLES(EN_MIN)
    ) u_en_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (en_s),
        .spoil   (1'b0),
        .held    (en_held),
        .released(en_released)
    );

    // Fault sources: unmasked over-current or supply undervoltage.
    assign trip = (oc_s & ~blank) | uv_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAULT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAULT: begin
                if (!trip && frst_done && !en_s)
                    state_d = ST_IDLE;                // CLEAR
            end
            ST_IDLE: begin
                if (trip)
                    state_d = ST_FAULT;               // TRIP
                else if (en_held)
                    state_d = ST_RUN;                 // ARM
            end
            ST_RUN: begin
                if (trip)
                    state_d = ST_FAULT;               // TRIP
                else if (!en_s)
                    state_d = ST_IDLE;                // DISABLE
            end
            default: state_d = ST_FAULT;
        endcase
    end

    always_comb begin
        gate_kill = 1'b1;
        fault_n   = 1'b1;
        unique case (state_q)
            ST_FAULT: begin
                gate_kill = 1'b1;
                fault_n   = 1'b0;
            end
            ST_IDLE: begin
                gate_kill = 1'b1;
                fault_n   = 1'b1;
            end
            ST_RUN: begin
                gate_kill = 1'b0;
                fault_n   = 1'b1;
            end
            default: begin
                gate_kill = 1'b1;
                fault_n   = 1'b0;
            end
        endcase
    end

    // Qualifier outputs not needed by this state machine.
    logic unused_ok;
    assign unused_ok = &{1'b0, frst_held, en_released, hs_rise};

endmodule

// File: rtl/ocf_fault_ctrl_chk.sv
module ocf_fault_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic oc_s,
    input logic en_s,
    input logic uv_s,
    input logic blank,
    input logic gate_kill,
    input logic fault_n
);

    a_r12_kill_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> gate_kill);

    a_r3_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_s && !blank) |=> !fault_n);

    a_r5_uv_latches: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> !fault_n);

    a_r8_no_clear_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && en_s) |=> !fault_n);

    a_r4_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_n && oc_s && blank && !uv_s) |=> fault_n);

    a_r11_disable_kills: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> gate_kill);

    a_r10_release_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_kill) |-> $past(en_s));

endmodule

bind ocf_fault_ctrl ocf_fault_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .oc_s     (oc_s),
    .en_s     (en_s),
    .uv_s     (uv_s),
    .blank    (blank),
    .gate_kill(gate_kill),
    .fault_n  (fault_n)
);

// File: tb/ocf_fault_ctrl_bench.sv
module ocf_fault_ctrl_bench;

    localparam int NP = 3;
    localparam int S  = 2;
    localparam int B  = 10;
    localparam int F  = 6;
    localparam int E  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oc_raw = 1'b0;
    logic          en_raw = 1'b0;
    logic          frst_raw = 1'b0;
    logic          uv_raw = 1'b0;
    logic [NP-1:0] hs_cmd_raw = '0;
    logic          gate_kill;
    logic          fault_n;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    ocf_fault_ctrl #(
        .N_PHASE(NP), .SYNC_STAGES(S), .BLANK_CYCLES(B),
        .FRST_MIN(F), .EN_MIN(E)
    ) u_ocf_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .en_raw(en_raw),
        .frst_raw(frst_raw), .uv_raw(uv_raw), .hs_cmd_raw(hs_cmd_raw),
        .gate_kill(gate_kill), .fault_n(fault_n)
    );

    // Reference model built from the requirements: 0 latched, 1 cleared/disabled, 2 running.
    logic [6:0] mq [S];
    logic [NP-1:0] m_hsp;
    int m_bc, m_fc, m_ec, m_st;
    logic m_fp;

    function automatic logic exp_kill(int st);
        return st != 2;
    endfunction

    function automatic logic exp_fn(int st);
        return st != 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < S; i++) mq[i] = '0;
        m_hsp = '0; m_bc = 0; m_fc = 0; m_ec = 0; m_fp = 1'b0; m_st = 0;
    endtask

    task automatic model_step();
        logic [6:0] y;
        logic oc, en, fr, uv, rise, blank, trip, fdone, eheld;
        logic [NP-1:0] hs;
        int nst;
        y = mq[S-1];
        oc = y[0]; en = y[1]; fr = y[2]; uv = y[3]; hs = y[6:4];
        rise  = |(hs & ~m_hsp);
        blank = rise || (m_bc != 0);
        trip  = (oc && !blank) || uv;
        fdone = m_fp && !fr && (m_fc == F);
        eheld = en && (m_ec == E);
        nst = m_st;
        case (m_st)
            0: if (!trip && fdone && !en) nst = 1;
            1: if (trip) nst = 0; else if (eheld) nst = 2;
            default: if (trip) nst = 0; else if (!en) nst = 1;
        endcase
        if (rise) m_bc = B - 1; else if (m_bc != 0) m_bc = m_bc - 1;
        m_hsp = hs;
        if (!fr || en || oc || uv) m_fc = 0; else if (m_fc != F) m_fc = m_fc + 1;
        m_fp = fr;
        if (!en) m_ec = 0; else if (m_ec != E) m_ec = m_ec + 1;
        m_st = nst;
        for (int i = S - 1; i > 0; i--) mq[i] = mq[i-1];
        mq[0] = {hs_cmd_raw, uv_raw, frst_raw, en_raw, oc_raw};
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (gate_kill !== exp_kill(m_st) || fault_n !== exp_fn(m_st)) begin
                fails++;
                $display("FAIL %s model: kill=%b fault_n=%b expected kill=%b fault_n=%b",
                         cur_req, gate_kill, fault_n, exp_kill(m_st), exp_fn(m_st));
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_now(string req, logic ek, logic ef);
        checks++;
        if (gate_kill !== ek || fault_n !== ef) begin
            fails++;
            $display("FAIL %s: kill=%b fault_n=%b expected kill=%b fault_n=%b",
                     req, gate_kill, fault_n, ek, ef);
        end
    endtask

    task automatic clear_seq();
        en_raw = 1'b0; cyc(3);
        frst_raw = 1'b1; cyc(F + 3);
        frst_raw = 1'b0; cyc(S + 3);
    endtask

    task automatic arm_seq();
        en_raw = 1'b1; cyc(E + S + 4);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        check_now("R1", 1'b1, 1'b0);

        cur_req = "R6";
        clear_seq();
        check_now("R6", 1'b1, 1'b1);

        cur_req = "R10";
        en_raw = 1'b1; cyc(3);
        check_now("R10", 1'b1, 1'b1);
        cyc(E + 4);
        check_now("R10", 1'b0, 1'b1);

        cur_req = "R2";
        oc_raw = 1'b1; cyc(S);
        check_now("R2", 1'b0, 1'b1);
        cyc(1);
        check_now("R3", 1'b1, 1'b0);
        cur_req = "R3";
        cyc(2); oc_raw = 1'b0; cyc(3);
        check_now("R3", 1'b1, 1'b0);

        cur_req = "R8";
        frst_raw = 1'b1; cyc(F + 3); frst_raw = 1'b0; cyc(S + 3);
        check_now("R8", 1'b1, 1'b0);

        cur_req = "R7";
        en_raw = 1'b0; cyc(3);
        frst_raw = 1'b1; cyc(F - 2); frst_raw = 1'b0; cyc(S + 3);
        check_now("R7", 1'b1, 1'b0);

        cur_req = "R9";
        frst_raw = 1'b1; cyc(4);
        oc_raw = 1'b1; cyc(2); oc_raw = 1'b0;
        cyc(F - 2); frst_raw = 1'b0; cyc(S + 3);
        check_now("R9", 1'b1, 1'b0);
        clear_seq();
        check_now("R6", 1'b1, 1'b1);

        cur_req = "R11";
        arm_seq();
        check_now("R10", 1'b0, 1'b1);
        en_raw = 1'b0; cyc(S + 2);
        check_now("R11", 1'b1, 1'b1);
        en_raw = 1'b1; cyc(E - 2); en_raw = 1'b0; cyc(S + 3);
        check_now("R10", 1'b1, 1'b1);

        cur_req = "R4";
        arm_seq();
        hs_cmd_raw = 3'b010; oc_raw = 1'b1; cyc(B); oc_raw = 1'b0; cyc(S + 2);
        check_now("R4", 1'b0, 1'b1);
        hs_cmd_raw = 3'b000; cyc(3);
        hs_cmd_raw = 3'b100; oc_raw = 1'b1; cyc(B + 1); oc_raw = 1'b0; cyc(S + 2);
        check_now("R4", 1'b1, 1'b0);
        hs_cmd_raw = 3'b000;

        cur_req = "R5";
        clear_seq();
        arm_seq();
        check_now("R5", 1'b0, 1'b1);
        uv_raw = 1'b1; cyc(1); uv_raw = 1'b0; cyc(S + 2);
        check_now("R5", 1'b1, 1'b0);
        check_now("R12", 1'b1, 1'b0);

        cur_req = "R3 R4 R6 R12 random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 11) == 0) frst_raw = ~frst_raw;
            if ($urandom_range(0, 24) == 0) en_raw = ~en_raw;
            oc_raw = ($urandom_range(0, 14) == 0);
            uv_raw = ($urandom_range(0, 299) == 0);
            if ($urandom_range(0, 7) == 0) hs_cmd_raw = 3'($urandom_range(0, 7));
            cyc(1);
        end

        summary();
        $finish;
    end

endmodule